// File: doc/BRIEF.md
# Flash Read Address Remap and Decryption Bypass Unit

This block sits in the flash read path, between the system read bus and the flash back end. It inspects every access. A read that lands inside a programmable page window of the flash alias space is moved to another location by adding a programmed displacement to its address. Program and erase accesses always keep their original address. For each access the block also decides whether the on-the-fly decryption engine is used. Up to four page ranges can be marked as plain-text storage, and reads from those ranges skip decryption even when global AES is on.

The configuration arrives on static input vectors. Register programming and the decryption datapath belong to other blocks. Bypass matching looks only at the untranslated source address. The forwarded address is the translated one, so security-mark lookups downstream use the post-displacement location. When the flash sits behind the external QSPI controller, the bypass ranges have no effect. A remap window that overlaps a bypass range in internal-flash mode is an unsupported setup. The block flags it and leaves addresses unchanged. All results leave through a single register stage.

Top module: `flash_remap_unit`

## Requirements
- R1: An address is in the flash window only when bits [31:25] equal 7'h04 (base 0x0800_0000) or 7'h06 (base 0x0C00_0000), giving a 32 MB window per alias. For an address outside the window, the address is forwarded unchanged and the decrypt flag equals `aes_en_i`.
- R2: Consider a read (`acc_kind_i` = 0) inside the window whose page index, address bits [24:12], lies in the inclusive range [`ofs_lo_i`, `ofs_hi_i`]. Its forwarded address is the bus address plus `ofs_value_i`, modulo 2^32. Pages just outside that range are not moved.
- R3: Program (`acc_kind_i` = 1) and erase (`acc_kind_i` = 2) accesses are forwarded with their address unchanged, even inside the remap range.
- R4: In internal mode (`ext_mode_i` = 0), an access inside the window whose source page lies in any enabled bypass range gets decrypt flag 0. Any other access gets decrypt flag equal to `aes_en_i`. Bypass range n occupies bits [13n+12:13n] of `byp_lo_i` and `byp_hi_i`.
- R5: In external mode (`ext_mode_i` = 1), the bypass ranges are ignored and the decrypt flag equals `aes_en_i`. The remap still applies.
- R6: Bypass matching uses the source address. A read moved into a bypass range from outside it keeps decrypt flag `aes_en_i`, and its forwarded address is the translated one.
- R7: A range whose low page index is greater than its high page index is disabled. It matches nothing and takes no part in the overlap check.
- R8: In internal mode, `cfg_err_o` is 1 one cycle after an enabled remap range overlaps any enabled bypass range. While that overlap exists, no read is moved. In external mode the overlap is not an error.
- R9: The results of an access presented with `acc_valid_i` high at a clock edge appear on the outputs after that edge, with `out_valid_o` high for exactly that cycle. Without a valid access, `out_addr_o` and `out_decrypt_o` hold their values.
- R10: While `rst_n` is low, `out_valid_o`, `out_addr_o`, `out_decrypt_o` and `cfg_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | 32 | Bus address of the access |
| acc_kind_i | input | 2 | 0 read, 1 program, 2 erase, 3 reserved (treated as non-read) |
| ext_mode_i | input | 1 | 1 = external QSPI flash, 0 = internal flash |
| aes_en_i | input | 1 | Global decryption enable |
| ofs_lo_i | input | 13 | First page of the remap range |
| ofs_hi_i | input | 13 | Last page of the remap range |
| ofs_value_i | input | 32 | Displacement added to remapped reads |
| byp_lo_i | input | 52 | First page of each of four bypass ranges |
| byp_hi_i | input | 52 | Last page of each of four bypass ranges |
| out_valid_o | output | 1 | Registered access valid |
| out_addr_o | output | 32 | Forwarded (translated) address, also used for security marking |
| out_decrypt_o | output | 1 | 1 = pass read data through decryption |
| cfg_err_o | output | 1 | Remap/bypass overlap in internal mode |

## Verification
Every access result is due exactly one rising edge after the access is presented. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. Configuration changes work the same way: `cfg_err_o` is sampled one falling edge after the new range values are applied. Hold behaviour is checked by changing the address with valid low and sampling two falling edges later.

// File: rtl/flash_remap_pkg.sv
package flash_remap_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_PROG  = 2'd1,
    ACC_ERASE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic [31:0] addr;
    logic        decrypt;
  } fwd_info_t;

endpackage

// File: rtl/flash_page_range.sv
module flash_page_range #(
  parameter int PG_W = 13
) (
  input  logic [PG_W-1:0] page_i,
  input  logic [PG_W-1:0] lo_i,
  input  logic [PG_W-1:0] hi_i,
  output logic            hit_o
);

  logic enabled;

  always_comb begin
    enabled = (lo_i <= hi_i);
    hit_o   = enabled && (page_i >= lo_i) && (page_i <= hi_i);
  end

endmodule

// File: rtl/flash_range_overlap.sv
module flash_range_overlap #(
  parameter int PG_W = 13
) (
  input  logic [PG_W-1:0] a_lo_i,
  input  logic [PG_W-1:0] a_hi_i,
  input  logic [PG_W-1:0] b_lo_i,
  input  logic [PG_W-1:0] b_hi_i,
  output logic            overlap_o
);

  logic a_en;
  logic b_en;

  always_comb begin
    a_en      = (a_lo_i <= a_hi_i);
    b_en      = (b_lo_i <= b_hi_i);
    overlap_o = a_en && b_en && (a_lo_i <= b_hi_i) && (b_lo_i <= a_hi_i);
  end

endmodule

// File: rtl/flash_remap_stage.sv
module flash_remap_stage
  import flash_remap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic              in_decrypt_i,
  input  logic              in_err_i,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic              out_decrypt_o,
  output logic              out_err_o
);

  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              dec_q, dec_d;
  logic              err_q, err_d;

  // next-state: access fields load only under the valid enable
  always_comb begin
    valid_d = in_valid_i;
    err_d   = in_err_i;
    addr_d  = addr_q;
    dec_d   = dec_q;
    if (in_valid_i) begin
      addr_d = in_addr_i;
      dec_d  = in_decrypt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      dec_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      dec_q   <= dec_d;
      err_q   <= err_d;
    end
  end

  assign out_valid_o   = valid_q;
  assign out_addr_o    = addr_q;
  assign out_decrypt_o = dec_q;
  assign out_err_o     = err_q;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> (!out_valid_o && $stable(out_addr_o) && $stable(out_decrypt_o))); // R9

endmodule

// File: rtl/flash_remap_unit.sv
module flash_remap_unit
  import flash_remap_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          WIN_W    = 25,
  parameter int          PAGE_LSB = 12,
  parameter int          N_BYPASS = 4,
  parameter logic [31:0] NS_BASE  = 32'h0800_0000,
  parameter logic [31:0] S_BASE   = 32'h0C00_0000
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               acc_valid_i,
  input  logic [ADDR_W-1:0]                  acc_addr_i,
  input  logic [1:0]                         acc_kind_i,
  input  logic                               ext_mode_i,
  input  logic                               aes_en_i,
  input  logic [WIN_W-PAGE_LSB-1:0]          ofs_lo_i,
  input  logic [WIN_W-PAGE_LSB-1:0]          ofs_hi_i,
  input  logic [ADDR_W-1:0]                  ofs_value_i,
  input  logic [N_BYPASS*(WIN_W-PAGE_LSB)-1:0] byp_lo_i,
  input  logic [N_BYPASS*(WIN_W-PAGE_LSB)-1:0] byp_hi_i,
  output logic                               out_valid_o,
  output logic [ADDR_W-1:0]                  out_addr_o,
  output logic                               out_decrypt_o,
  output logic                               cfg_err_o
);

  localparam int PG_W  = WIN_W - PAGE_LSB;
  localparam int TAG_W = ADDR_W - WIN_W;
  localparam logic [TAG_W-1:0] NS_TAG = NS_BASE[ADDR_W-1:WIN_W];
  localparam logic [TAG_W-1:0] S_TAG  = S_BASE[ADDR_W-1:WIN_W];

  acc_kind_e         kind;
  logic [TAG_W-1:0]  src_tag;
  logic [PG_W-1:0]   src_page;
  logic              in_win;
  logic              ofs_hit;
  logic [N_BYPASS-1:0] byp_hit;
  logic [N_BYPASS-1:0] byp_ovl;
  logic              byp_any;
  logic              cfg_conflict;
  logic              do_ofs;
  fwd_info_t         fwd;

  always_comb begin
    kind     = acc_kind_e'(acc_kind_i);
    src_tag  = acc_addr_i[ADDR_W-1:WIN_W];
    src_page = acc_addr_i[WIN_W-1:PAGE_LSB];
    in_win   = (src_tag == NS_TAG) || (src_tag == S_TAG);
  end

  flash_page_range #(.PG_W(PG_W)) u_ofs_range (
    .page_i (src_page),
    .lo_i   (ofs_lo_i),
    .hi_i   (ofs_hi_i),
    .hit_o  (ofs_hit)
  );

  for (genvar g = 0; g < N_BYPASS; g++) begin : g_byp
    flash_page_range #(.PG_W(PG_W)) u_range (
      .page_i (src_page),
      .lo_i   (byp_lo_i[g*PG_W +: PG_W]),
      .hi_i   (byp_hi_i[g*PG_W +: PG_W]),
      .hit_o  (byp_hit[g])
    );

    flash_range_overlap #(.PG_W(PG_W)) u_ovl (
      .a_lo_i    (ofs_lo_i),
      .a_hi_i    (ofs_hi_i),
      .b_lo_i    (byp_lo_i[g*PG_W +: PG_W]),
      .b_hi_i    (byp_hi_i[g*PG_W +: PG_W]),
      .overlap_o (byp_ovl[g])
    );
  end

  // bypass and conflict only exist for internal flash
  always_comb begin
    byp_any      = in_win && (|byp_hit) && !ext_mode_i;
    cfg_conflict = (|byp_ovl) && !ext_mode_i;
    do_ofs       = in_win && ofs_hit && (kind == ACC_READ) && !cfg_conflict;
    fwd.addr     = do_ofs ? (acc_addr_i + ofs_value_i) : acc_addr_i;
    fwd.decrypt  = aes_en_i && !byp_any;
  end

  flash_remap_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid_i    (acc_valid_i),
    .in_addr_i     (fwd.addr),
    .in_decrypt_i  (fwd.decrypt),
    .in_err_i      (cfg_conflict),
    .out_valid_o   (out_valid_o),
    .out_addr_o    (out_addr_o),
    .out_decrypt_o (out_decrypt_o),
    .out_err_o     (cfg_err_o)
  );

  AST_WRITE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_kind_i != 2'd0) |=> out_addr_o == $past(acc_addr_i)); // R3

  AST_EXT_AES_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && ext_mode_i) |=> out_decrypt_o == $past(aes_en_i)); // R5

  AST_AES_OFF_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !aes_en_i) |=> !out_decrypt_o); // R4

  AST_CONFLICT_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && cfg_conflict) |=> out_addr_o == $past(acc_addr_i)); // R8

  AST_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !in_win) |=> (out_addr_o == $past(acc_addr_i) &&
                                  out_decrypt_o == $past(aes_en_i))); // R1

  AST_ERR_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode_i |=> !cfg_err_o); // R8

endmodule

// File: tb/flash_remap_unit_test.sv
module flash_remap_unit_test;

  localparam int PG_W = 13;

  logic        clk;
  logic        rst_n;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic [1:0]  acc_kind;
  logic        ext_mode;
  logic        aes_en;
  logic [PG_W-1:0] ofs_lo, ofs_hi;
  logic [31:0] ofs_value;
  logic [4*PG_W-1:0] byp_lo, byp_hi;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        out_decrypt;
  logic        cfg_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  flash_remap_unit uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid_i   (acc_valid),
    .acc_addr_i    (acc_addr),
    .acc_kind_i    (acc_kind),
    .ext_mode_i    (ext_mode),
    .aes_en_i      (aes_en),
    .ofs_lo_i      (ofs_lo),
    .ofs_hi_i      (ofs_hi),
    .ofs_value_i   (ofs_value),
    .byp_lo_i      (byp_lo),
    .byp_hi_i      (byp_hi),
    .out_valid_o   (out_valid),
    .out_addr_o    (out_addr),
    .out_decrypt_o (out_decrypt),
    .cfg_err_o     (cfg_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_byp(input int idx, input logic [PG_W-1:0] lo, input logic [PG_W-1:0] hi);
    byp_lo[idx*PG_W +: PG_W] = lo;
    byp_hi[idx*PG_W +: PG_W] = hi;
  endtask

  // present one access; results sampled one rising edge later
  task automatic do_acc(input logic [31:0] a, input logic [1:0] k);
    @(negedge clk);
    acc_addr  = a;
    acc_kind  = k;
    acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 valid", {31'd0, out_valid}, 32'd0);
    chk("R10 addr", out_addr, 32'd0);
    chk("R10 decrypt", {31'd0, out_decrypt}, 32'd0);
    chk("R10 err", {31'd0, cfg_err}, 32'd0);
  endtask

  task automatic t_remap;
    do_acc(32'h0801_0040, 2'd0);
    chk("R2 ns remap", out_addr, 32'h0811_0040);
    chk("R6 src-based decrypt", {31'd0, out_decrypt}, 32'd1);
    do_acc(32'h0C01_F004, 2'd0);
    chk("R1 secure alias remap", out_addr, 32'h0C11_F004);
    do_acc(32'h0802_0000, 2'd0);
    chk("R2 page above range", out_addr, 32'h0802_0000);
    do_acc(32'h0800_FFFC, 2'd0);
    chk("R2 page below range", out_addr, 32'h0800_FFFC);
  endtask

  task automatic t_writes;
    do_acc(32'h0801_0040, 2'd1);
    chk("R3 program", out_addr, 32'h0801_0040);
    do_acc(32'h0C01_0080, 2'd2);
    chk("R3 erase", out_addr, 32'h0C01_0080);
  endtask

  task automatic t_bypass;
    do_acc(32'h0820_0010, 2'd0);
    chk("R4 bypass hit", {31'd0, out_decrypt}, 32'd0);
    do_acc(32'h0830_0000, 2'd0);
    chk("R4 no hit", {31'd0, out_decrypt}, 32'd1);
    aes_en = 1'b0;
    do_acc(32'h0830_0000, 2'd0);
    chk("R4 aes off", {31'd0, out_decrypt}, 32'd0);
    aes_en = 1'b1;
  endtask

  task automatic t_ext;
    ext_mode = 1'b1;
    do_acc(32'h0820_0010, 2'd0);
    chk("R5 ext ignores bypass", {31'd0, out_decrypt}, 32'd1);
    do_acc(32'h0801_0040, 2'd0);
    chk("R5 ext remap", out_addr, 32'h0811_0040);
    ext_mode = 1'b0;
  endtask

  task automatic t_outside;
    do_acc(32'h0A01_0040, 2'd0);
    chk("R1 outside no remap", out_addr, 32'h0A01_0040);
    do_acc(32'h0A20_0010, 2'd0);
    chk("R1 outside no bypass", {31'd0, out_decrypt}, 32'd1);
  endtask

  task automatic t_disabled;
    set_byp(0, 13'h2FF, 13'h200);
    do_acc(32'h0825_0000, 2'd0);
    chk("R7 bypass disabled", {31'd0, out_decrypt}, 32'd1);
    set_byp(0, 13'h200, 13'h2FF);
    ofs_lo = 13'h01F; ofs_hi = 13'h010;
    do_acc(32'h0801_0040, 2'd0);
    chk("R7 remap disabled", out_addr, 32'h0801_0040);
    ofs_lo = 13'h010; ofs_hi = 13'h01F;
  endtask

  task automatic t_conflict;
    @(negedge clk);
    set_byp(2, 13'h018, 13'h018);
    @(negedge clk);
    chk("R8 err raised", {31'd0, cfg_err}, 32'd1);
    do_acc(32'h0801_0040, 2'd0);
    chk("R8 no remap", out_addr, 32'h0801_0040);
    ext_mode = 1'b1;
    @(negedge clk);
    chk("R8 ext no err", {31'd0, cfg_err}, 32'd0);
    do_acc(32'h0801_0040, 2'd0);
    chk("R8 ext remap", out_addr, 32'h0811_0040);
    ext_mode = 1'b0;
    set_byp(2, 13'h001, 13'h000);
    @(negedge clk);
    chk("R8 err cleared", {31'd0, cfg_err}, 32'd0);
  endtask

  task automatic t_latency;
    do_acc(32'h0801_0040, 2'd0);
    chk("R9 valid pulse", {31'd0, out_valid}, 32'd1);
    acc_addr = 32'h0830_0000;
    aes_en   = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 valid low", {31'd0, out_valid}, 32'd0);
    chk("R9 addr hold", out_addr, 32'h0811_0040);
    chk("R9 decrypt hold", {31'd0, out_decrypt}, 32'd1);
    aes_en = 1'b1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_kind = 2'd0;
    ext_mode = 1'b0; aes_en = 1'b1;
    ofs_lo = 13'h010; ofs_hi = 13'h01F; ofs_value = 32'h0010_0000;
    byp_lo = '0; byp_hi = '0;
    set_byp(0, 13'h200, 13'h2FF);
    set_byp(1, 13'h110, 13'h11F);
    set_byp(2, 13'h001, 13'h000);
    set_byp(3, 13'h001, 13'h000);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_remap();
    t_writes();
    t_bypass();
    t_ext();
    t_outside();
    t_disabled();
    t_conflict();
    t_latency();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule